// File: doc/BRIEF.md
# System and Per-CPU Interval Timer Set

This block holds one system-wide interval timer and one private interval timer for each CPU. The system timer drives a level-10 interrupt line. Each CPU timer drives its own level-14 line. Every timer counts up by one for each cycle in which `tick_en` is high. When the count meets the programmed limit, the count restarts at 1 and the timer's interrupt flag latches. The system timer therefore fires once every `limit` ticks. A CPU timer can be armed once and then stopped by writing a zero limit.

Software reaches the timers over a simple word-addressed register bus. Write data is taken when `bus_wr` is high. Read data on `bus_rdata` is combinational from `bus_addr`. Reading a timer's limit register acknowledges its interrupt. A second address, the quiet limit alias, returns and updates the same limit without touching the flag. A mode register can switch each CPU timer into a free-running user counter. In that mode a per-CPU run bit gates the counter and no interrupt is raised.

Top module: `ivl_timer_set`

## Requirements
- R1: After reset every limit is 0, every count is 1, every interrupt flag is 0, the mode register is 0 and every run bit is 0.
- R2: In timer mode with a nonzero limit, the count rises by exactly 1 on each clock edge with `tick_en` high, and it holds on edges with `tick_en` low.
- R3: On a tick where the count equals the nonzero limit, the count becomes 1 and the interrupt flag is set. Counting goes on, so the flag is set again every `limit` ticks.
- R4: A read of a limit register (register offset 0) clears that timer's flag at the next edge. If the same edge also reaches the limit, the flag stays set.
- R5: The quiet limit alias (register offset 2) reads the limit and writes the limit without changing the flag or the count.
- R6: A write to a limit register (offset 0) loads bits 30:10 of the write data as the limit, sets the count to 1 and clears the flag.
- R7: While a timer in timer mode has a limit of 0, its count holds and its flag is never set.
- R8: The count register (offset 1) reads back as bit 31 = flag, bits 30:10 = count and all other bits 0. Writes to it are ignored. Limit reads return the limit in bits 30:10 and 0 elsewhere.
- R9: Mode register bit i set to 1 puts CPU timer i in user-counter mode. In that mode the timer counts on each tick only while bit 0 of its run register is 1, it wraps at the top of the field, and it never sets its flag. Writing 0 to the mode register returns every CPU timer to timer mode.
- R10: CPU timer i occupies word addresses 4i..4i+3 (limit, count, quiet limit, run). The system timer sits at 4*NUM_CPUS..4*NUM_CPUS+3, with the mode register at the last of these. Unmapped addresses read 0 and ignore writes. At most one register is written per cycle.
- R11: `irq_sys` equals the system timer's flag, and `irq_cpu[i]` equals CPU timer i's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one tick per high cycle |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for read side effects) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_sys | output | 1 | System timer interrupt (level 10) |
| irq_cpu | output | NUM_CPUS | Per-CPU timer interrupts (level 14) |

## Verification
The bench runs the system timer through a table of limits and tick counts, including limit 1 and tick counts that land one short of the limit, exactly on it, and past it. A design off by one in the restart value would show a wrong count or a missing flag at these points. Directed tests cover several cases: a clearing read on the same edge as a new limit hit, which a design that lets the clear win would drop; quiet-alias reads and writes, which a wrong design would use to clear the flag or reset the count; and a zero limit, which must neither count nor interrupt. User-counter mode is checked with the run bit held off and then on, and for freedom from interrupts, because a design that ignored the mode bit would raise `irq_cpu`.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  localparam int FIELD_LSB = 10;
  localparam int FIELD_MSB = 30;
  localparam int FIELD_W   = FIELD_MSB - FIELD_LSB + 1;

  typedef logic [FIELD_W-1:0] field_t;

  typedef struct packed {
    field_t next;
    logic   hit;
  } step_t;

  typedef enum logic [1:0] {
    REG_LIMIT    = 2'd0,
    REG_COUNT    = 2'd1,
    REG_LIMIT_NC = 2'd2,
    REG_AUX      = 2'd3
  } reg_sel_e;

  function automatic field_t field_of(input logic [31:0] w);
    return w[FIELD_MSB:FIELD_LSB];
  endfunction

  function automatic logic [31:0] pack_field(input logic top, input field_t f);
    return {top, f, {FIELD_LSB{1'b0}}};
  endfunction

  // timer-mode advance: restart at 1 on meeting the limit
  function automatic step_t timer_step(input field_t cnt, input field_t lim);
    step_t s;
    if (cnt == lim) begin
      s.next = field_t'(1);
      s.hit  = 1'b1;
    end else begin
      s.next = cnt + 1'b1;
      s.hit  = 1'b0;
    end
    return s;
  endfunction
endpackage

// File: rtl/ivl_timer_decode.sv
module ivl_timer_decode #(
  parameter int NUM_CPUS = 2,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic                rd,
  output logic [NUM_CPUS:0]   lim_wr,
  output logic [NUM_CPUS:0]   nc_wr,
  output logic [NUM_CPUS:0]   lim_rd,
  output logic [NUM_CPUS-1:0] run_wr,
  output logic                cfg_wr,
  output logic                hit_map,
  output logic [ADDR_W-3:0]   unit_o,
  output ivl_timer_pkg::reg_sel_e sel_o
);
  import ivl_timer_pkg::*;
  localparam int NUNITS = NUM_CPUS + 1;

  assign unit_o  = addr[ADDR_W-1:2];
  assign sel_o   = reg_sel_e'(addr[1:0]);
  assign hit_map = (int'(unit_o) < NUNITS);

  always_comb begin
    lim_wr = '0;
    nc_wr  = '0;
    lim_rd = '0;
    run_wr = '0;
    cfg_wr = 1'b0;
    if (hit_map) begin
      case (sel_o)
        REG_LIMIT: begin
          lim_wr[unit_o] = wr;
          lim_rd[unit_o] = rd;
        end
        REG_LIMIT_NC: nc_wr[unit_o] = wr;
        REG_AUX: begin
          if (int'(unit_o) == NUM_CPUS) cfg_wr = wr;
          else                          run_wr[unit_o] = wr;
        end
        default: ;
      endcase
    end
  end

  // R10
  dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lim_wr, nc_wr, run_wr, cfg_wr}));
endmodule

// File: rtl/ivl_timer_slice.sv
module ivl_timer_slice (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  user_mode,
  input  logic                  run,
  input  logic                  lim_wr,
  input  logic                  nc_wr,
  input  ivl_timer_pkg::field_t wfield,
  input  logic                  clr_rd,
  output ivl_timer_pkg::field_t limit_o,
  output ivl_timer_pkg::field_t count_o,
  output logic                  flag_o,
  output logic                  hit_o
);
  import ivl_timer_pkg::*;

  field_t lim_q, cnt_q;
  logic   flag_q;
  step_t  st;
  logic   armed;

  assign st    = timer_step(cnt_q, lim_q);
  assign armed = !user_mode && (lim_q != '0);
  assign hit_o = tick && armed && st.hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q  <= '0;
      cnt_q  <= field_t'(1);
      flag_q <= 1'b0;
    end else if (lim_wr) begin
      lim_q  <= wfield;
      cnt_q  <= field_t'(1);
      flag_q <= 1'b0;
    end else begin
      if (nc_wr) lim_q <= wfield;
      if (tick) begin
        if (user_mode) begin
          if (run) cnt_q <= cnt_q + 1'b1;
        end else if (armed) begin
          cnt_q <= st.next;
        end
      end
      if (hit_o)       flag_q <= 1'b1;
      else if (clr_rd) flag_q <= 1'b0;
    end
  end

  assign limit_o = lim_q;
  assign count_o = cnt_q;
  assign flag_o  = flag_q;

  // R3
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !lim_wr) |=> (flag_o && count_o == field_t'(1)));
  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && !hit_o && !lim_wr) |=> !flag_o);
  // R6
  lim_wr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lim_wr |=> (!flag_o && count_o == field_t'(1)));
  // R7
  zero_limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_o == '0 && !user_mode && !lim_wr) |=> ($stable(count_o) && !$rose(flag_o)));
  // R9
  user_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && !lim_wr) |=> !$rose(flag_o));
  // R2
  tick_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && armed && !hit_o && !lim_wr) |=> (count_o == field_t'($past(count_o) + 1'b1)));
endmodule

// File: rtl/ivl_timer_set.sv
module ivl_timer_set #(
  parameter int NUM_CPUS = 2,
  localparam int ADDR_W  = $clog2(4 * (NUM_CPUS + 1))
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                irq_sys,
  output logic [NUM_CPUS-1:0] irq_cpu
);
  import ivl_timer_pkg::*;
  localparam int NUNITS = NUM_CPUS + 1;

  logic [NUM_CPUS:0]   lim_wr, nc_wr, lim_rd, hit_w, flag_w;
  logic [NUM_CPUS-1:0] run_wr;
  logic                cfg_wr, hit_map;
  logic [ADDR_W-3:0]   unit;
  reg_sel_e            sel;
  logic [NUM_CPUS-1:0] cfg_q, run_q;
  field_t              lim_a [NUNITS];
  field_t              cnt_a [NUNITS];
  field_t              wfield;

  assign wfield = field_of(bus_wdata);

  ivl_timer_decode #(.NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W)) dec_i (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .lim_wr(lim_wr), .nc_wr(nc_wr), .lim_rd(lim_rd), .run_wr(run_wr),
    .cfg_wr(cfg_wr), .hit_map(hit_map), .unit_o(unit), .sel_o(sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      run_q <= '0;
    end else begin
      if (cfg_wr) cfg_q <= bus_wdata[NUM_CPUS-1:0];
      for (int i = 0; i < NUM_CPUS; i++)
        if (run_wr[i]) run_q[i] <= bus_wdata[0];
    end
  end

  for (genvar g = 0; g < NUNITS; g++) begin : g_unit
    logic um, rn;
    if (g < NUM_CPUS) begin : g_cpu
      assign um = cfg_q[g];
      assign rn = run_q[g];
    end else begin : g_sys
      assign um = 1'b0;
      assign rn = 1'b0;
    end
    ivl_timer_slice slice_i (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .user_mode(um), .run(rn),
      .lim_wr(lim_wr[g]), .nc_wr(nc_wr[g]), .wfield(wfield), .clr_rd(lim_rd[g]),
      .limit_o(lim_a[g]), .count_o(cnt_a[g]), .flag_o(flag_w[g]), .hit_o(hit_w[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_map) begin
      case (sel)
        REG_LIMIT, REG_LIMIT_NC: bus_rdata = pack_field(1'b0, lim_a[unit]);
        REG_COUNT:               bus_rdata = pack_field(flag_w[unit], cnt_a[unit]);
        REG_AUX: begin
          if (int'(unit) == NUM_CPUS) bus_rdata = 32'(cfg_q);
          else                        bus_rdata = {31'b0, run_q[unit]};
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq_sys = flag_w[NUM_CPUS];
  assign irq_cpu = flag_w[NUM_CPUS-1:0];

  // R11
  irq_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_w[NUM_CPUS] && !lim_wr[NUM_CPUS]) |=> irq_sys);
endmodule

// File: tb/ivl_timer_set_tb.sv
`timescale 1ns/1ps
module ivl_timer_set_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_sys;
  logic [1:0]  irq_cpu;

  int nchk = 0;
  int nfail = 0;
  logic [31:0] d;

  always #4 clk = ~clk;

  ivl_timer_set #(.NUM_CPUS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_sys(irq_sys), .irq_cpu(irq_cpu)
  );

  // {limit[20:0], ticks[7:0], expected count[20:0], expected flag}
  localparam logic [50:0] VEC [8] = '{
    {21'd5, 8'd3, 21'd4, 1'b0},
    {21'd5, 8'd4, 21'd5, 1'b0},
    {21'd5, 8'd5, 21'd1, 1'b1},
    {21'd5, 8'd7, 21'd3, 1'b1},
    {21'd1, 8'd0, 21'd1, 1'b0},
    {21'd1, 8'd1, 21'd1, 1'b1},
    {21'd3, 8'd6, 21'd1, 1'b1},
    {21'd2, 8'd0, 21'd1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  function automatic logic [31:0] lw(input int v);
    return 32'(v) << 10;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R11 reset state
    #1;
    chk("R1 irq_sys", {31'b0, irq_sys}, 32'd0);
    chk("R11 irq_cpu", {30'b0, irq_cpu}, 32'd0);
    rd(4'd9, d);  chk("R1 sys count", d, lw(1));
    rd(4'd8, d);  chk("R1 sys limit", d, 32'd0);
    rd(4'd11, d); chk("R1 mode reg", d, 32'd0);
    rd(4'd3, d);  chk("R1 run bit", d, 32'd0);

    // R3 table walk on the system timer
    for (int i = 0; i < 8; i++) begin
      logic [50:0] v;
      v = VEC[i];
      wr(4'd8, lw(int'(v[50:30])));
      ticks(int'(v[29:22]));
      #1 chk("R11 irq_sys vs table", {31'b0, irq_sys}, {31'b0, v[0]});
      rd(4'd9, d);
      chk("R3 count/flag table", d, {v[0], v[21:1], 10'b0});
    end

    // R5 quiet alias read keeps the flag, R4 limit read clears it
    wr(4'd8, lw(2)); ticks(2);
    rd(4'd10, d); chk("R5 quiet read value", d, lw(2));
    #1 chk("R5 quiet read keeps flag", {31'b0, irq_sys}, 32'd1);
    rd(4'd8, d);
    #1 chk("R4 limit read clears flag", {31'b0, irq_sys}, 32'd0);

    // R5 quiet write keeps count, R2 advance
    wr(4'd8, lw(4)); ticks(2);
    wr(4'd10, lw(6));
    rd(4'd9, d);  chk("R5 quiet write keeps count", d, lw(3));
    rd(4'd10, d); chk("R5 quiet write new limit", d, lw(6));
    ticks(3);
    rd(4'd9, d);  chk("R2 count advance", d, lw(6));
    ticks(1);
    rd(4'd9, d);  chk("R3 hit at new limit", d, 32'h8000_0000 | lw(1));

    // R6 limit write clears pending flag
    wr(4'd8, lw(4));
    #1 chk("R6 write clears flag", {31'b0, irq_sys}, 32'd0);
    rd(4'd9, d); chk("R6 write resets count", d, lw(1));

    // R4 hit on the same edge as a clearing read: flag stays
    wr(4'd8, lw(2)); ticks(1);
    @(negedge clk); bus_addr = 4'd8; bus_rd = 1'b1; tick_en = 1'b1;
    @(negedge clk); bus_rd = 1'b0; tick_en = 1'b0;
    #1 chk("R4 hit beats clear", {31'b0, irq_sys}, 32'd1);

    // R8 count writes ignored
    wr(4'd9, 32'h7fff_fc00);
    rd(4'd9, d); chk("R8 count write ignored", d, 32'h8000_0400);
    // R2 no tick, no change
    repeat (10) @(negedge clk);
    rd(4'd9, d); chk("R2 idle hold", d, 32'h8000_0400);

    // R3 one-shot on CPU timer 0, R7 zero limit stops it
    wr(4'd0, lw(3)); ticks(3);
    #1 chk("R11 cpu0 irq", {30'b0, irq_cpu}, 32'd1);
    rd(4'd0, d);
    #1 chk("R4 cpu0 clear", {30'b0, irq_cpu}, 32'd0);
    wr(4'd0, 32'd0); ticks(10);
    #1 chk("R7 zero limit no irq", {30'b0, irq_cpu}, 32'd0);
    rd(4'd1, d); chk("R7 zero limit holds count", d, lw(1));

    // R9 user-counter mode on CPU timer 1
    wr(4'd11, 32'd2);
    rd(4'd11, d); chk("R9 mode readback", d, 32'd2);
    wr(4'd4, lw(2)); ticks(3);
    rd(4'd5, d); chk("R9 stopped holds", d, lw(1));
    wr(4'd7, 32'd1); ticks(5);
    rd(4'd5, d); chk("R9 running counts past limit", d, lw(6));
    #1 chk("R9 user mode no irq", {30'b0, irq_cpu}, 32'd0);
    wr(4'd7, 32'd0); ticks(2);
    rd(4'd7, d); chk("R10 run readback", d, 32'd0);
    rd(4'd5, d); chk("R9 stop holds", d, lw(6));
    wr(4'd11, 32'd0); wr(4'd4, lw(2)); ticks(2);
    #1 chk("R9 timer mode restored", {30'b0, irq_cpu}, 32'd2);

    // R10 unmapped address
    wr(4'd13, 32'hffff_ffff);
    rd(4'd13, d); chk("R10 unmapped reads 0", d, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule